// File: doc/BRIEF.md
# Window-Attributed Pixel Format Decoder

This block sits on the display refresh path and turns stored pixel words into 32-bit colour words with 8 bits each of alpha, red, green and blue. Every pixel arrives with a window identifier. That identifier selects one entry of a 32-entry attribute table. The entry supplies a format code, a palette bank, a front/back buffer select and a gamma-bypass flag. The format code decides how the pixel word is read. An indexed pixel is resolved through a 1024-word colour map. A packed direct pixel has each field widened to 8 bits.

Software loads the colour map and the attribute table through a single write port. One address-space bit chooses between the two targets. Pixels move on a valid/ready stream. The pipeline is two registers deep and stalls as a whole when the consumer is not ready.

Top module: `pxd_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: When `out_ready` stays high, a pixel accepted at one rising edge appears on `out_valid`/`out_rgba` after the second rising edge, and not after the first.
- R3: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_rgba`, `out_buf_b` and `out_gamma_off` hold their values. Pixels leave in the order they were accepted.
- R4: A write with `reg_space`=1 updates attribute entry `reg_addr[6:2]`. Word `reg_addr[1:0]` chooses the field: 0 is the format code (`reg_wdata[3:0]`), 1 is the palette bank (`reg_wdata[3:0]`), 2 is the buffer select (`reg_wdata[0]`, 1 = buffer B), and 3 is the gamma bypass (`reg_wdata[0]`). `out_buf_b` and `out_gamma_off` carry the flags of the entry named by the pixel's `in_wid`.
- R5: Format 0xA (8-bit indexed) outputs the colour-map word at address (bank × 64 + pixel[7:0]) modulo 1024, unchanged.
- R6: A write with `reg_space`=0 stores `reg_wdata` in colour-map address `reg_addr[9:0]`. The word is packed as alpha in [31:24], red in [23:16], green in [15:8] and blue in [7:0], which is also the layout of `out_rgba`.
- R7: Adding 4 to a format code bypasses the palette. For 0xE the output is grey: red, green and blue each equal pixel[7:0], and alpha is 0xFF. For every direct format the added 4 has no effect.
- R8: Format 1 (5-6-5) takes blue from [4:0], green from [10:5] and red from [15:11]. Each field is widened by copying its top bits into the vacated low bits, and alpha is 0xFF.
- R9: Format 2 (1-5-5-5) takes blue from [4:0], green from [9:5] and red from [14:10], widened as in R8. Alpha is 0xFF when bit 15 is 1 and 0x00 when it is 0.
- R10: Format 9 (3-3-2) takes blue from [1:0], green from [4:2] and red from [7:5], widened by repeating each field, and alpha is 0xFF.
- R11: Format 0 (24-bit) passes [23:0] through as red, green and blue with alpha 0xFF. Format 3 (32-bit) passes all 32 bits through, alpha included.
- R12: A colour-map write that falls in the same cycle as the acceptance of an indexed pixel reading that same address gives that pixel the old word. The next pixel sees the new word.
- R13: Format codes 8, 0xB, 0xC and 0xF output 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel word present |
| in_ready | output | 1 | Pixel accepted when high together with in_valid |
| in_data | input | 32 | Stored pixel word |
| in_wid | input | 5 | Window identifier selecting the attribute entry |
| reg_we | input | 1 | Register write strobe |
| reg_space | input | 1 | 0 = colour map, 1 = attribute table |
| reg_addr | input | 10 | Write address |
| reg_wdata | input | 32 | Write data |
| out_valid | output | 1 | Decoded colour present |
| out_ready | input | 1 | Consumer takes the colour |
| out_rgba | output | 32 | Alpha, red, green, blue (high to low) |
| out_buf_b | output | 1 | Buffer select from the pixel's attribute entry |
| out_gamma_off | output | 1 | Gamma bypass from the pixel's attribute entry |

## Verification
The interaction most likely to hide a bug is a colour-map write that falls in the same cycle as an indexed pixel looking up the same address. The bench provokes it by driving `reg_we` and `in_valid` on the same clock edge, with the write aimed at the address that pixel reads. It judges the result by requiring the old word on that pixel and the new word on the pixel sent right after it. A consumer stall that lands while a second pixel is already in flight is also driven. The bench requires the held output to stay steady and the queued pixels to leave in order.

// File: rtl/pxd_pkg.sv
package pxd_pkg;
   localparam int PIX_W  = 32;
   localparam int BANK_W = 4;
   localparam int IDX_W  = 8;

   localparam logic [3:0] FMT_RGB24   = 4'h0;
   localparam logic [3:0] FMT_RGB565  = 4'h1;
   localparam logic [3:0] FMT_ARGB1555= 4'h2;
   localparam logic [3:0] FMT_ARGB32  = 4'h3;
   localparam logic [3:0] FMT_NOPAL   = 4'h4;
   localparam logic [3:0] FMT_RGB332  = 4'h9;
   localparam logic [3:0] FMT_IDX8    = 4'hA;

   typedef struct packed {
      logic [3:0]        fmt;
      logic [BANK_W-1:0] bank;
      logic              buf_b;
      logic              gamma_off;
   } win_attr_t;
endpackage

// File: rtl/pxd_attr_table.sv
module pxd_attr_table
   import pxd_pkg::*;
#(
   parameter int WID_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WID_W-1:0] widx,
   input  logic [1:0]       word,
   input  logic [3:0]       wdata,
   input  logic [WID_W-1:0] rd_wid,
   output win_attr_t        rd_attr
);
   localparam int NUM_WIN = 1 << WID_W;

   win_attr_t ent_q [NUM_WIN];

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q[g] <= '0;
         end else if (we && (widx == WID_W'(g))) begin
            unique case (word)
               2'd0: ent_q[g].fmt       <= wdata;
               2'd1: ent_q[g].bank      <= wdata[BANK_W-1:0];
               2'd2: ent_q[g].buf_b     <= wdata[0];
               2'd3: ent_q[g].gamma_off <= wdata[0];
            endcase
         end
      end
   end

   assign rd_attr = ent_q[rd_wid];
endmodule

// File: rtl/pxd_palette.sv
module pxd_palette #(
   parameter int AW = 10,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // read-before-write: a same-edge write is not seen by the read
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/pxd_expand.sv
module pxd_expand
   import pxd_pkg::*;
(
   input  logic [3:0]       fmt,
   input  logic [PIX_W-1:0] pix,
   input  logic [31:0]      pal,
   output logic [31:0]      rgba
);
   function automatic logic [7:0] wid5(input logic [4:0] v);
      return {v, v[4:2]};
   endfunction

   function automatic logic [7:0] wid6(input logic [5:0] v);
      return {v, v[5:4]};
   endfunction

   function automatic logic [7:0] wid3(input logic [2:0] v);
      return {v, v, v[2:1]};
   endfunction

   always_comb begin
      unique case (fmt)
         FMT_IDX8:
            rgba = pal;
         FMT_IDX8 | FMT_NOPAL:
            rgba = {8'hFF, pix[7:0], pix[7:0], pix[7:0]};
         FMT_RGB565, FMT_RGB565 | FMT_NOPAL:
            rgba = {8'hFF, wid5(pix[15:11]), wid6(pix[10:5]), wid5(pix[4:0])};
         FMT_ARGB1555, FMT_ARGB1555 | FMT_NOPAL:
            rgba = {{8{pix[15]}}, wid5(pix[14:10]), wid5(pix[9:5]), wid5(pix[4:0])};
         FMT_RGB332, FMT_RGB332 | FMT_NOPAL:
            rgba = {8'hFF, wid3(pix[7:5]), wid3(pix[4:2]), {4{pix[1:0]}}};
         FMT_RGB24, FMT_RGB24 | FMT_NOPAL:
            rgba = {8'hFF, pix[23:0]};
         FMT_ARGB32, FMT_ARGB32 | FMT_NOPAL:
            rgba = pix;
         default:
            rgba = '0;
      endcase
   end
endmodule

// File: rtl/pxd_top.sv
module pxd_top
   import pxd_pkg::*;
#(
   parameter int WID_W      = 5,
   parameter int PAL_AW     = 10,
   parameter int BANK_SHIFT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [PIX_W-1:0]  in_data,
   input  logic [WID_W-1:0]  in_wid,
   input  logic              reg_we,
   input  logic              reg_space,
   input  logic [PAL_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [31:0]       out_rgba,
   output logic              out_buf_b,
   output logic              out_gamma_off
);
   if (PAL_AW < WID_W + 2) begin : g_chk_aw
      $error("PAL_AW too narrow for attribute addressing");
   end
   if (BANK_SHIFT + BANK_W > PAL_AW || BANK_SHIFT < IDX_W - 2) begin : g_chk_bank
      $error("BANK_SHIFT does not fit the colour map");
   end

   logic              adv;
   win_attr_t         cur_attr;
   logic [PAL_AW-1:0] bank_base;
   logic [PAL_AW-1:0] pal_raddr;
   logic [31:0]       pal_q;
   logic              use_pal;

   logic              s1_valid;
   logic [PIX_W-1:0]  s1_pix;
   logic [3:0]        s1_fmt;
   logic              s1_buf_b;
   logic              s1_gam;
   logic [31:0]       dec_rgba;

   // whole pipe advances unless a finished colour is being held
   assign adv      = !(out_valid && !out_ready);
   assign in_ready = adv;

   pxd_attr_table #(.WID_W(WID_W)) u_attr (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we && reg_space),
      .widx   (reg_addr[WID_W+1:2]),
      .word   (reg_addr[1:0]),
      .wdata  (reg_wdata[3:0]),
      .rd_wid (in_wid),
      .rd_attr(cur_attr)
   );

   assign bank_base = PAL_AW'(cur_attr.bank) << BANK_SHIFT;
   assign pal_raddr = bank_base + PAL_AW'(in_data[IDX_W-1:0]);
   assign use_pal   = (cur_attr.fmt == FMT_IDX8);

   pxd_palette #(.AW(PAL_AW), .DW(32)) u_pal (
      .clk   (clk),
      .we    (reg_we && !reg_space),
      .waddr (reg_addr),
      .wdata (reg_wdata),
      .re    (adv && in_valid && use_pal),
      .raddr (pal_raddr),
      .rdata (pal_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_pix   <= '0;
         s1_fmt   <= '0;
         s1_buf_b <= 1'b0;
         s1_gam   <= 1'b0;
      end else if (adv) begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_pix   <= in_data;
            s1_fmt   <= cur_attr.fmt;
            s1_buf_b <= cur_attr.buf_b;
            s1_gam   <= cur_attr.gamma_off;
         end
      end
   end

   pxd_expand u_exp (
      .fmt (s1_fmt),
      .pix (s1_pix),
      .pal (pal_q),
      .rgba(dec_rgba)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_rgba      <= '0;
         out_buf_b     <= 1'b0;
         out_gamma_off <= 1'b0;
      end else if (adv) begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            out_rgba      <= dec_rgba;
            out_buf_b     <= s1_buf_b;
            out_gamma_off <= s1_gam;
         end
      end
   end
endmodule

// File: rtl/pxd_top_chk.sv
module pxd_top_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        in_ready,
   input logic        out_valid,
   input logic        out_ready,
   input logic [31:0] out_rgba,
   input logic        out_buf_b,
   input logic        out_gamma_off
);
   AST_RESET_EMPTY: assert property (@(posedge clk)
      !rst_n |=> !out_valid);  // R1

   AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid && in_ready, 2) && $past(out_ready)) |-> out_valid);  // R2

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_rgba) && $stable(out_buf_b) && $stable(out_gamma_off)));  // R3

   AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);  // R3
endmodule

bind pxd_top pxd_top_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_rgba     (out_rgba),
   .out_buf_b    (out_buf_b),
   .out_gamma_off(out_gamma_off)
);

// File: tb/tb_pxd_top.sv
`timescale 1ns/1ps
module tb_pxd_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        in_ready;
   logic [31:0] in_data;
   logic [4:0]  in_wid;
   logic        reg_we;
   logic        reg_space;
   logic [9:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic        out_valid;
   logic        out_ready;
   logic [31:0] out_rgba;
   logic        out_buf_b;
   logic        out_gamma_off;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   pxd_top dut (.*);

   typedef struct packed {
      logic [3:0]  fmt;
      logic [3:0]  bank;
      logic [31:0] pix;
      logic [31:0] exp;
      logic [23:0] req;
   } vec_t;

   // index in the table is also the window identifier used
   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{4'hA, 4'd0,  32'h0000_0005, 32'h1122_3344, "R5"},   // bank 0
      '{4'hA, 4'd3,  32'h0000_0010, 32'hA0B0_C0D0, "R5"},   // bank 3
      '{4'hA, 4'd15, 32'h0000_00FF, 32'hCAFE_F00D, "R5"},   // wraps to 191
      '{4'hE, 4'd0,  32'h0000_005C, 32'hFF5C_5C5C, "R7"},   // grey bypass
      '{4'h1, 4'd0,  32'h0000_8410, 32'hFF84_8284, "R8"},
      '{4'h1, 4'd0,  32'h0000_F81F, 32'hFFFF_00FF, "R8"},
      '{4'h2, 4'd0,  32'h0000_FC00, 32'hFFFF_0000, "R9"},
      '{4'h2, 4'd0,  32'h0000_03FF, 32'h0000_FFFF, "R9"},
      '{4'h9, 4'd0,  32'h0000_00B6, 32'hFFB6_B6AA, "R10"},
      '{4'h0, 4'd0,  32'h1234_5678, 32'hFF34_5678, "R11"},
      '{4'h3, 4'd0,  32'h1234_5678, 32'h1234_5678, "R11"},
      '{4'h5, 4'd0,  32'h0000_8410, 32'hFF84_8284, "R7"},   // no effect on direct
      '{4'h8, 4'd0,  32'h1234_5678, 32'h0000_0000, "R13"},
      '{4'hD, 4'd0,  32'h0000_00B6, 32'hFFB6_B6AA, "R7"}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic sp, input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_space = sp; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic send_chk(input logic [4:0] w, input logic [31:0] d,
                           input logic [31:0] exp, input string req);
      @(negedge clk);
      in_valid = 1'b1; in_wid = w; in_data = d;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check(req, {31'd0, out_valid}, 32'd1);
      check(req, out_rgba, exp);
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_wid = '0;
      reg_we = 1'b0; reg_space = 1'b0; reg_addr = '0; reg_wdata = '0;
      out_ready = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", {30'd0, out_valid, in_ready}, 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {30'd0, out_valid, in_ready}, 32'd1);

      // R6 colour-map loads
      reg_wr(1'b0, 10'd5,   32'h1122_3344);
      reg_wr(1'b0, 10'd208, 32'hA0B0_C0D0);
      reg_wr(1'b0, 10'd191, 32'hCAFE_F00D);

      for (int i = 0; i < NV; i++) begin
         reg_wr(1'b1, 10'((i << 2) | 0), {28'd0, VECS[i].fmt});
         reg_wr(1'b1, 10'((i << 2) | 1), {28'd0, VECS[i].bank});
         reg_wr(1'b1, 10'((i << 2) | 2), 32'(i & 1));
         reg_wr(1'b1, 10'((i << 2) | 3), 32'((i >> 1) & 1));
         send_chk(5'(i), VECS[i].pix, VECS[i].exp, string'(VECS[i].req));
         // R4 flags from the selected entry
         check("R4", {30'd0, out_gamma_off, out_buf_b}, 32'(i & 3));
      end

      // R2 latency: nothing after one edge, result after two
      @(negedge clk);
      in_valid = 1'b1; in_wid = 5'd9; in_data = 32'h00AB_CDEF;
      @(negedge clk);
      in_valid = 1'b0;
      check("R2", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      check("R2", {31'd0, out_valid}, 32'd1);
      check("R2", out_rgba, 32'hFFAB_CDEF);

      // R3 stall with a second pixel in flight
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1'b1; in_wid = 5'd9; in_data = 32'h0001_0203;
      @(negedge clk);
      in_data = 32'h00A0_B0C0;
      @(negedge clk);
      in_data = 32'h0011_1111;
      check("R3", {30'd0, out_valid, in_ready}, 32'd2);
      check("R3", out_rgba, 32'hFF01_0203);
      repeat (3) @(negedge clk);
      check("R3", {30'd0, out_valid, in_ready}, 32'd2);
      check("R3", out_rgba, 32'hFF01_0203);
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R3", out_rgba, 32'hFFA0_B0C0);
      @(negedge clk);
      check("R3", out_rgba, 32'hFF11_1111);
      @(negedge clk);
      check("R3", {31'd0, out_valid}, 32'd0);

      // R12 same-cycle write and read of entry 5 (window 0 is indexed, bank 0)
      @(negedge clk);
      reg_we = 1'b1; reg_space = 1'b0; reg_addr = 10'd5; reg_wdata = 32'h5566_7788;
      in_valid = 1'b1; in_wid = 5'd0; in_data = 32'h0000_0005;
      @(negedge clk);
      reg_we = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      check("R12", out_rgba, 32'h1122_3344);
      send_chk(5'd0, 32'h0000_0005, 32'h5566_7788, "R12");

      // R7 grey path does not consult the map at the rewritten address
      send_chk(5'd3, 32'h0000_0005, 32'hFF05_0505, "R7");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule